// File: doc/BRIEF.md
# Oversampled Serial Register-Write Slave

This block receives 16-bit write frames from a serial master and turns them into writes to a small bank of 8-bit control registers. All of its logic runs on the system clock. The serial clock, the active-low select and the serial data line are each passed through a two-flop synchronizer. A further flop keeps the previous synchronized serial-clock level, and comparing the two gives a falling-edge pulse. That pulse samples the synchronized data bit.

Bits arrive most significant first. The first byte of a frame selects the register and the second byte is its new value. When the sixteenth bit has been captured, the selected register is written in one system-clock cycle. A one-cycle strobe reports the address and data at the same moment. The register bank is presented as one flat parallel output. The system clock must run faster than four times the serial clock.

Top module: `spi_regwr_slave`

## Requirements
- R1: After synchronous reset, every register reads zero and `wr_stb` is low.
- R2: Data bits are taken on the falling edge of `sck_in`. A value that `sdi_in` holds only before the rising edge of a bit is not captured.
- R3: Within a frame, bits 15..8 (first sent, MSB first) form the address and bits 7..0 form the data. Register k appears on `regs_out[8*k+7 : 8*k]`.
- R4: A frame whose address is 12 or greater changes no register and raises no strobe.
- R5: If `csn_in` rises before the sixteenth bit, nothing is written. The next frame starts again at bit 15.
- R6: For each valid frame, `wr_stb` is high for exactly one cycle with `wr_addr`/`wr_data` equal to the frame fields. The register shows the new value in the following cycle.
- R7: Several frames sent back to back under one low period of `csn_in` are each written in turn.
- R8: Serial-clock activity while `csn_in` is high writes nothing and leaves the bit count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_in | input | 1 | Asynchronous serial clock, idle low |
| csn_in | input | 1 | Asynchronous frame select, active low |
| sdi_in | input | 1 | Asynchronous serial data |
| regs_out | output | 96 | All control registers, register k at bits 8k+7..8k |
| wr_stb | output | 1 | One-cycle pulse for each accepted write |
| wr_addr | output | 8 | Address field of the current frame |
| wr_data | output | 8 | Data field of the current frame |

## Verification
The hardest case to produce at the ports is capture on the wrong serial-clock edge. A normal driver holds data steady across the whole bit, so a design that samples on the rising edge would still produce correct results. To separate the two, the stimulus drives the inverted bit value during the low phase and up to the rising edge. It then switches to the true value one system cycle after the rise and holds it through the fall. Only falling-edge capture gives the intended frame. Aborted partial frames and clock activity while the select is high come next. Each is followed by a clean frame, which shows whether the bit counter was left at zero.

// File: rtl/spi_regwr_pkg.sv
package spi_regwr_pkg;
  localparam int unsigned ADDR_BITS  = 8;
  localparam int unsigned DATA_BITS  = 8;
  localparam int unsigned FRAME_BITS = ADDR_BITS + DATA_BITS;

  // Address field sits in the first-sent (upper) bits of a frame
  function automatic logic [ADDR_BITS-1:0] frame_addr(input logic [FRAME_BITS-1:0] f);
    return f[FRAME_BITS-1 -: ADDR_BITS];
  endfunction

  function automatic logic [DATA_BITS-1:0] frame_data(input logic [FRAME_BITS-1:0] f);
    return f[DATA_BITS-1:0];
  endfunction

  function automatic logic addr_in_range(input logic [ADDR_BITS-1:0] a, input int unsigned n);
    return 32'(a) < n;
  endfunction
endpackage

// File: rtl/spi_bit_sync.sv
module spi_bit_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {STAGES{RST_VAL}};
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_frame_shift.sv
module spi_frame_shift
  import spi_regwr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_act,
  input  logic                  bit_stb,
  input  logic                  bit_in,
  output logic [FRAME_BITS-1:0] frame_q,
  output logic                  frame_done
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS);

  logic [CNT_W-1:0] cnt;
  logic             last_bit;
  logic             take;

  assign take     = cs_act && bit_stb;
  assign last_bit = (cnt == CNT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      frame_q    <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= take && last_bit;
      if (!cs_act) begin
        cnt <= '0;
      end else if (bit_stb) begin
        frame_q <= {frame_q[FRAME_BITS-2:0], bit_in};
        cnt     <= last_bit ? '0 : cnt + 1'b1;
      end
    end
  end

  p_cnt_clear_r5: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (cnt == '0));

  p_shift_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> $stable(frame_q));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_regwr_pkg::*;
#(
  parameter int unsigned NUM_REGS = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [ADDR_BITS-1:0]          addr,
  input  logic [DATA_BITS-1:0]          data,
  output logic [NUM_REGS*DATA_BITS-1:0] q_flat
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_BITS-1:0] q_r;
    logic                 sel;

    assign sel = we && (addr == ADDR_BITS'(i));

    always_ff @(posedge clk) begin
      if (rst)      q_r <= '0;
      else if (sel) q_r <= data;
    end

    assign q_flat[i*DATA_BITS +: DATA_BITS] = q_r;

    p_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
      (we && addr == ADDR_BITS'(i)) |=> (q_flat[i*DATA_BITS +: DATA_BITS] == $past(data)));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !(we && addr == ADDR_BITS'(i)) |=> $stable(q_flat[i*DATA_BITS +: DATA_BITS]));
  end
endmodule

// File: rtl/spi_regwr_slave.sv
module spi_regwr_slave
  import spi_regwr_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sck_in,
  input  logic                          csn_in,
  input  logic                          sdi_in,
  output logic [NUM_REGS*DATA_BITS-1:0] regs_out,
  output logic                          wr_stb,
  output logic [ADDR_BITS-1:0]          wr_addr,
  output logic [DATA_BITS-1:0]          wr_data
);
  // Index 0 = sck, 1 = csn, 2 = sdi; all share the same delay
  localparam logic [2:0] IDLE_LEVELS = 3'b010;

  logic [2:0]            raw_in;
  logic [2:0]            sync_in;
  logic                  sck_prev;
  logic                  sck_fall;
  logic                  cs_act;
  logic [FRAME_BITS-1:0] frame_q;
  logic                  frame_done;

  assign raw_in = {sdi_in, csn_in, sck_in};

  for (genvar k = 0; k < 3; k++) begin : g_sync
    spi_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LEVELS[k])) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw_in[k]),
      .q   (sync_in[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b0;
    else     sck_prev <= sync_in[0];
  end

  assign sck_fall = sck_prev && !sync_in[0];
  assign cs_act   = !sync_in[1];

  spi_frame_shift u_shift (
    .clk        (clk),
    .rst        (rst),
    .cs_act     (cs_act),
    .bit_stb    (sck_fall),
    .bit_in     (sync_in[2]),
    .frame_q    (frame_q),
    .frame_done (frame_done)
  );

  assign wr_addr = frame_addr(frame_q);
  assign wr_data = frame_data(frame_q);
  assign wr_stb  = frame_done && addr_in_range(wr_addr, NUM_REGS);

  spi_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_stb),
    .addr   (wr_addr),
    .data   (wr_data),
    .q_flat (regs_out)
  );

  p_stb_after_fall_r2: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(sck_fall));

  p_stb_single_r6: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  p_idle_no_stb_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!cs_act) |-> !wr_stb);
endmodule

// File: tb/spi_regwr_slave_test.sv
module spi_regwr_slave_test;
  localparam int NREG = 12;
  localparam int H    = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sck = 1'b0;
  logic              csn = 1'b1;
  logic              sdi = 1'b0;
  logic [NREG*8-1:0] regs_out;
  logic              wr_stb;
  logic [7:0]        wr_addr;
  logic [7:0]        wr_data;

  int checks = 0;
  int fails  = 0;
  int stb_cnt = 0;
  int exp_stb = 0;
  int double_stb = 0;
  bit finished = 0;
  logic [7:0] last_addr, last_data;
  logic [7:0] exp_regs [NREG];
  bit   pend = 0;
  logic [7:0] pend_addr, pend_data;
  bit   prev_stb = 0;

  always #4 clk = ~clk;

  spi_regwr_slave uut (
    .clk(clk), .rst(rst), .sck_in(sck), .csn_in(csn), .sdi_in(sdi),
    .regs_out(regs_out), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Strobe monitor; R6 timing of the register update
  always @(negedge clk) begin
    if (!rst) begin
      if (pend) begin
        check(regs_out[int'(pend_addr)*8 +: 8] == pend_data, "R6",
              "register one cycle after strobe", int'(regs_out[int'(pend_addr)*8 +: 8]), int'(pend_data));
        pend = 0;
      end
      if (wr_stb) begin
        stb_cnt++;
        last_addr = wr_addr;
        last_data = wr_data;
        if (prev_stb) double_stb++;
        if (wr_addr < NREG) begin
          pend = 1; pend_addr = wr_addr; pend_data = wr_data;
        end
      end
      prev_stb = wr_stb;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // late=1: wrong value until one cycle after the rising edge (R2)
  task automatic send_bits(input logic [15:0] w, input int nbits, input bit late);
    for (int i = 15; i > 15 - nbits; i--) begin
      sdi = late ? ~w[i] : w[i];
      tick(H);
      sck = 1'b1;
      tick(1);
      sdi = w[i];
      tick(H - 1);
      sck = 1'b0;
      tick(H);
    end
  endtask

  task automatic cs_low();  csn = 1'b0; tick(H); endtask
  task automatic cs_high(); tick(H); csn = 1'b1; tick(2*H); endtask

  task automatic expect_write(input logic [7:0] a, input logic [7:0] d);
    if (a < NREG) begin
      exp_regs[a] = d;
      exp_stb++;
    end
  endtask

  task automatic do_frame(input logic [7:0] a, input logic [7:0] d, input bit late);
    cs_low();
    send_bits({a, d}, 16, late);
    cs_high();
    expect_write(a, d);
  endtask

  task automatic compare_all(input string req);
    for (int r = 0; r < NREG; r++)
      check(regs_out[r*8 +: 8] == exp_regs[r], req, $sformatf("reg %0d", r),
            int'(regs_out[r*8 +: 8]), int'(exp_regs[r]));
    check(stb_cnt == exp_stb, req, "strobe count", stb_cnt, exp_stb);
  endtask

  function automatic logic [7:0] pat(input int a, input int k);
    return 8'((a * 29 + k * 113 + 7) & 255);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NREG; r++) exp_regs[r] = 8'h00;
    tick(4);
    // R1: reset state
    check(regs_out == '0, "R1", "regs after reset", int'(regs_out[31:0]), 0);
    check(wr_stb == 1'b0, "R1", "strobe in reset", int'(wr_stb), 0);
    rst = 1'b0;
    tick(3);
    compare_all("R1");

    // R3/R6: sweep every address with two patterns
    for (int k = 0; k < 2; k++) begin
      for (int a = 0; a < NREG; a++) begin
        do_frame(8'(a), pat(a, k), 1'b0);
        check(last_addr == 8'(a), "R3", "strobe address", int'(last_addr), a);
        check(last_data == pat(a, k), "R3", "strobe data", int'(last_data), int'(pat(a, k)));
      end
      compare_all("R3");
    end

    // R2: data valid only from after the rising edge through the fall
    for (int a = 0; a < NREG; a += 5) do_frame(8'(a), ~pat(a, 3), 1'b1);
    compare_all("R2");

    // R4: out-of-range addresses are ignored
    for (int a = NREG; a < 16; a++) do_frame(8'(a), 8'hA5, 1'b0);
    do_frame(8'hFF, 8'h3C, 1'b0);
    do_frame(8'h80, 8'h11, 1'b0);
    compare_all("R4");

    // R5: aborted partial frame, then a clean one
    cs_low();
    send_bits({8'd3, 8'hEE}, 10, 1'b0);
    cs_high();
    compare_all("R5");
    do_frame(8'd4, 8'h5A, 1'b0);
    compare_all("R5");
    check(last_addr == 8'd4, "R5", "address after abort", int'(last_addr), 4);

    // R7: two frames in one select period
    cs_low();
    send_bits({8'd7, 8'hC3}, 16, 1'b0);
    send_bits({8'd11, 8'h69}, 16, 1'b0);
    cs_high();
    expect_write(8'd7, 8'hC3);
    expect_write(8'd11, 8'h69);
    compare_all("R7");

    // R8: clocking with select high, then a clean frame
    send_bits({8'd2, 8'hFF}, 16, 1'b0);
    send_bits({8'd9, 8'h00}, 7, 1'b0);
    tick(2*H);
    compare_all("R8");
    do_frame(8'd9, 8'h96, 1'b0);
    compare_all("R8");

    tick(4);
    check(double_stb == 0, "R6", "strobe wider than one cycle", double_stb, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule